// File: doc/BRIEF.md
# PWM Counter Submodule with Reload-Driven DMA Request

This block is one PWM counter submodule. It has six compare values, a start value for the counter, and double-buffered loading of all of them. Software or a DMA engine writes new values into a shadow bank. The values take effect only at a reload point, and only if a load-ok flag was armed before that point. The counter counts up from the start value to the second compare value and then wraps. A match with the first compare value is the mid-period reload point. A match with the second compare value is the end-of-period reload point. Each reload point has its own enable.

When an enabled reload point is hit and the DMA enable is set, the block raises a DMA request. An external DMA engine can then refill the shadow bank for the next period or half period. The request is a level. It is held until the engine acknowledges it. Further reload events are not queued while the request is pending. The third and fourth compare values drive a single PWM output. The fifth and sixth compare values are stored and switched like the others, but no match against them ever produces a request.

Top module: `pwm_reload_sub`

## Requirements
- R1: After reset the counter output is 0, the PWM output is 0, the DMA request is 0, load-ok is 0, and every shadow and active register holds 0.
- R2: Each clock the counter advances by one, with two's-complement wrap over CNT_W bits. In the cycle after the counter equals the active VAL1 (the value at index 1), it takes the active start value (index 6) instead.
- R3: With the half enable set, a cycle in which the counter equals the active VAL0 (index 0) is a reload event.
- R4: With the full enable set, a cycle in which the counter equals the active VAL1 is a reload event.
- R5: Counter matches against VAL2 to VAL5 (indices 2 to 5) never raise the DMA request. With both reload enables clear, the request never rises.
- R6: The DMA request rises in the cycle after a reload event only if the DMA enable is set in the event cycle.
- R7: Once raised, the request stays high until a cycle with the acknowledge input high, and is low in the cycle after that. Reload events while the request is high, and in the acknowledge cycle, raise no further request.
- R8: A write with select 0 to 5 loads shadow VAL0 to VAL5, select 6 loads the shadow start value, and select 7 is ignored. At a reload event with load-ok set, all seven shadow values are copied to the active set and load-ok clears. With load-ok clear, shadow writes do not affect the active set.
- R9: A load-ok set pulse makes load-ok 1 in the next cycle. If a copy happens in the same cycle, the set wins.
- R10: In the cycle after the counter equals the active VAL2, the PWM output is 1. Otherwise, in the cycle after it equals the active VAL3, the output is 0. Otherwise the output holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Shadow register write strobe |
| wr_sel_i | input | 3 | Shadow register select (0-5 VAL0-VAL5, 6 start value, 7 none) |
| wr_data_i | input | CNT_W | Shadow write data |
| half_en_i | input | 1 | Enables reload at the VAL0 match |
| full_en_i | input | 1 | Enables reload at the VAL1 match |
| dma_en_i | input | 1 | Lets reload events raise the DMA request |
| ldok_set_i | input | 1 | Pulse that arms load-ok |
| dma_ack_i | input | 1 | DMA acknowledge |
| dma_req_o | output | 1 | DMA request level |
| pwm_o | output | 1 | PWM output |
| cnt_o | output | CNT_W | Current counter value |
| ldok_o | output | 1 | Current load-ok state |

## Verification
Directed phases each isolate one gate. With both reload enables off while the counter sweeps across every compare value, the phase shows that only VAL0 and VAL1 matches can request. With the DMA enable off, reload events that still copy values are separated from requests. With acknowledge held low across many reload events, the phase shows that pending events are not queued. Random shadow writes, load-ok pulses, enable changes and acknowledges then mix wraps, mid-period copies and same-cycle set/copy collisions. A cycle-level bench model flags any cycle where the counter, PWM, load-ok or request differs.

// File: rtl/pwmr_pkg.sv
package pwmr_pkg;
  localparam int NREG     = 7;
  localparam int SEL_W    = 3;
  localparam int IDX_V0   = 0;
  localparam int IDX_V1   = 1;
  localparam int IDX_V2   = 2;
  localparam int IDX_V3   = 3;
  localparam int IDX_INIT = 6;
endpackage

// File: rtl/pwmr_regbank.sv
module pwmr_regbank
  import pwmr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [SEL_W-1:0] wr_sel_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             ldok_set_i,
  input  logic             reload_i,
  output logic [CNT_W-1:0] act_o [NREG],
  output logic             ldok_o
);
  logic [CNT_W-1:0] shd_q [NREG];
  logic [CNT_W-1:0] act_q [NREG];
  logic             ldok_q;
  logic             copy;

  assign copy = reload_i & ldok_q;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        shd_q[g] <= '0;
        act_q[g] <= '0;
      end else begin
        if (wr_en_i && wr_sel_i == SEL_W'(g)) shd_q[g] <= wr_data_i;
        if (copy) act_q[g] <= shd_q[g];
      end
    end
    assign act_o[g] = act_q[g];

    // R8
    act_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(reload_i && ldok_o) |=> $stable(act_o[g]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         ldok_q <= 1'b0;
    else if (ldok_set_i) ldok_q <= 1'b1;
    else if (copy)       ldok_q <= 1'b0;
  end
  assign ldok_o = ldok_q;

  // R8
  ldok_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_i && ldok_o && !ldok_set_i |=> !ldok_o);
  // R9
  ldok_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ldok_set_i |=> ldok_o);
endmodule

// File: rtl/pwmr_counter.sv
module pwmr_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] init_i,
  input  logic [CNT_W-1:0] v0_i,
  input  logic [CNT_W-1:0] v1_i,
  input  logic [CNT_W-1:0] v2_i,
  input  logic [CNT_W-1:0] v3_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             hit0_o,
  output logic             hit1_o,
  output logic             hit2_o,
  output logic             hit3_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (cnt_q == v1_i)  cnt_q <= init_i;
    else                     cnt_q <= cnt_q + CNT_W'(1);
  end

  assign cnt_o  = cnt_q;
  assign hit0_o = (cnt_q == v0_i);
  assign hit1_o = (cnt_q == v1_i);
  assign hit2_o = (cnt_q == v2_i);
  assign hit3_o = (cnt_q == v3_i);

  // R2
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit1_o |=> cnt_o == $past(cnt_o) + CNT_W'(1));
  // R2
  cnt_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit1_o |=> cnt_o == $past(init_i));
endmodule

// File: rtl/pwmr_outputs.sv
module pwmr_outputs (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic reload_i,
  input  logic dma_en_i,
  input  logic dma_ack_i,
  input  logic hit2_i,
  input  logic hit3_i,
  output logic dma_req_o,
  output logic pwm_o
);
  logic req_q, pwm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    req_q <= 1'b0;
    else if (req_q) req_q <= ~dma_ack_i;
    else            req_q <= reload_i & dma_en_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pwm_q <= 1'b0;
    else if (hit2_i) pwm_q <= 1'b1;
    else if (hit3_i) pwm_q <= 1'b0;
  end

  assign dma_req_o = req_q;
  assign pwm_o     = pwm_q;

  // R7
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_o && !dma_ack_i |=> dma_req_o);
  // R7
  req_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_o && dma_ack_i |=> !dma_req_o);
  // R6
  req_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dma_req_o && !(reload_i && dma_en_i) |=> !dma_req_o);
  // R10
  pwm_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit2_i |=> pwm_o);
endmodule

// File: rtl/pwm_reload_sub.sv
module pwm_reload_sub
  import pwmr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [SEL_W-1:0] wr_sel_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             half_en_i,
  input  logic             full_en_i,
  input  logic             dma_en_i,
  input  logic             ldok_set_i,
  input  logic             dma_ack_i,
  output logic             dma_req_o,
  output logic             pwm_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ldok_o
);
  logic [CNT_W-1:0] act [NREG];
  logic hit0, hit1, hit2, hit3, reload;

  // only VAL0/VAL1 matches can be reload events
  assign reload = (half_en_i & hit0) | (full_en_i & hit1);

  pwmr_regbank #(.CNT_W(CNT_W)) u_bank (
    .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .wr_data_i, .ldok_set_i,
    .reload_i(reload), .act_o(act), .ldok_o
  );

  pwmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni,
    .init_i(act[IDX_INIT]), .v0_i(act[IDX_V0]), .v1_i(act[IDX_V1]),
    .v2_i(act[IDX_V2]), .v3_i(act[IDX_V3]),
    .cnt_o, .hit0_o(hit0), .hit1_o(hit1), .hit2_o(hit2), .hit3_o(hit3)
  );

  pwmr_outputs u_out (
    .clk_i, .rst_ni, .reload_i(reload), .dma_en_i, .dma_ack_i,
    .hit2_i(hit2), .hit3_i(hit3), .dma_req_o, .pwm_o
  );

  // R5
  no_en_no_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dma_req_o && !half_en_i && !full_en_i |=> !dma_req_o);
endmodule

// File: tb/sim_pwm_reload_sub.sv
module sim_pwm_reload_sub;
  localparam int W = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, half_en = 0, full_en = 0, dma_en = 0, ldok_set = 0, ack = 0;
  logic [2:0] sel = 0;
  logic [W-1:0] data = 0;
  logic req, pwm, ldok;
  logic [W-1:0] cnt;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pwm_reload_sub #(.CNT_W(W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(sel), .wr_data_i(data),
    .half_en_i(half_en), .full_en_i(full_en), .dma_en_i(dma_en), .ldok_set_i(ldok_set),
    .dma_ack_i(ack), .dma_req_o(req), .pwm_o(pwm), .cnt_o(cnt), .ldok_o(ldok)
  );

  // bench model
  logic [W-1:0] m_shd [7], m_act [7], m_cnt;
  logic m_pwm, m_req, m_ldok;

  task automatic chk(input logic [W-1:0] act_v, input logic [W-1:0] exp_v, input string tag);
    total++;
    if (act_v !== exp_v) begin
      bad++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act_v, exp_v);
    end
  endtask

  task automatic model_step();
    logic rl, cp;
    logic [W-1:0] n_shd [7];
    rl = (half_en && m_cnt == m_act[0]) || (full_en && m_cnt == m_act[1]);
    cp = rl && m_ldok;
    for (int i = 0; i < 7; i++) n_shd[i] = m_shd[i];
    if (wr_en && sel != 3'd7) n_shd[sel] = data;
    m_pwm = (m_cnt == m_act[2]) ? 1'b1 : (m_cnt == m_act[3]) ? 1'b0 : m_pwm;
    m_req = m_req ? !ack : (rl && dma_en);
    m_ldok = ldok_set ? 1'b1 : cp ? 1'b0 : m_ldok;
    m_cnt = (m_cnt == m_act[1]) ? m_act[6] : m_cnt + W'(1);
    for (int i = 0; i < 7; i++) begin
      if (cp) m_act[i] = m_shd[i];
      m_shd[i] = n_shd[i];
    end
  endtask

  // inputs already set at a negedge; advance one cycle and compare
  task automatic step(input string ctag, input string rtag);
    model_step();
    @(negedge clk);
    chk(cnt, m_cnt, ctag);
    chk(W'(pwm), W'(m_pwm), "R10 pwm");
    chk(W'(ldok), W'(m_ldok), "R9 ldok");
    chk(W'(req), W'(m_req), rtag);
  endtask

  task automatic wr(input int s, input logic [W-1:0] d);
    wr_en = 1; sel = 3'(s); data = d;
    step("R8 cnt", "R8 req");
    wr_en = 0;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seen;
    void'($urandom(32'd4242));
    for (int i = 0; i < 7; i++) begin m_shd[i] = '0; m_act[i] = '0; end
    m_cnt = '0; m_pwm = 0; m_req = 0; m_ldok = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk(cnt, 8'd0, "R1 cnt");
    chk(W'(pwm), 8'd0, "R1 pwm");
    chk(W'(req), 8'd0, "R1 req");
    chk(W'(ldok), 8'd0, "R1 ldok");

    // R8: shadow writes without load-ok leave active set at zero
    wr(0, 8'd8); wr(1, 8'd15); wr(2, 8'd3); wr(3, 8'd11);
    wr(4, 8'd5); wr(5, 8'd6); wr(6, 8'hFC); wr(7, 8'd99);
    full_en = 1;
    repeat (4) step("R8 cnt", "R8 req");
    chk(cnt, 8'd0, "R8 cnt held by zero VAL1");
    ldok_set = 1; step("R9 cnt", "R9 req"); ldok_set = 0;
    repeat (3) step("R8 cnt", "R8 req");

    // R5: VAL2..VAL5 matches and disabled reload points raise nothing
    half_en = 0; full_en = 0; dma_en = 1; seen = 0;
    for (int i = 0; i < 60; i++) begin step("R2 cnt", "R5 req"); seen |= int'(req); end
    chk(W'(seen), 8'd0, "R5 no request with enables off");

    // R6: DMA enable off blocks requests
    full_en = 1; half_en = 1; dma_en = 0; seen = 0;
    for (int i = 0; i < 60; i++) begin step("R2 cnt", "R6 req"); seen |= int'(req); end
    chk(W'(seen), 8'd0, "R6 no request with DMA disabled");

    // R3/R4/R7: request held without ack across several events
    dma_en = 1; full_en = 0; half_en = 1;
    for (int i = 0; i < 30; i++) step("R3 cnt", "R3 req");
    half_en = 0; full_en = 1;
    for (int i = 0; i < 30; i++) step("R4 cnt", "R4 req");
    chk(W'(req), 8'd1, "R7 request still pending");
    ack = 1; step("R7 cnt", "R7 req"); ack = 0;
    chk(W'(req), 8'd0, "R7 request dropped after ack");

    // random phase
    for (int i = 0; i < 6000; i++) begin
      int s;
      s = int'($urandom % 8);
      wr_en = ($urandom % 4) == 0;
      sel = 3'(s);
      if (s == 1)      data = W'(5 + $urandom % 20);
      else if (s == 6) data = W'(-int'($urandom % 6));
      else             data = W'($urandom % 26);
      ldok_set = ($urandom % 16) == 0;
      ack = ($urandom % 3) == 0;
      if (i % 64 == 0) begin
        half_en = $urandom % 2; full_en = $urandom % 2; dma_en = ($urandom % 4) != 0;
      end
      step("R2/R8 cnt", "R3/R4/R6/R7 req");
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule